// File: doc/BRIEF.md
# Streaming 4:2:2 Interleaved to 4:2:0 Planar Splitter with Luma Deinterlace

This block takes a raster of packed 4:2:2 video, one byte per cycle, and splits it into three component streams: luma, blue-difference chroma and red-difference chroma. Two packed byte orders are accepted, selected by an input pin. Each input row is cut at its right edge to an aligned output width. Luma is deinterlaced by keeping the even input rows and rebuilding every odd row from the four nearest even rows with a fixed four-tap filter. Chroma is brought to 4:2:0 by passing even rows and dropping odd rows, with no filtering.

The input is marked with a frame-start flag on the first byte of a frame and a line-start flag on the first byte of every row. There is no backpressure, so the input may pause at any time but is never stalled. Each output port carries a valid strobe, its byte, first-sample and last-sample line markers, and a fixed plane tag. Chroma leaves one cycle after its byte arrives. Luma leaves in row order two even rows behind the input. The last two output row pairs of each frame are drained from the line stores after the input frame ends. For that reason a new frame must wait for vertical blanking.

Top module: `uyvy420_split`

## Requirements
- R1: With `in_order` = 0, byte position k mod 4 in each row carries Cb for k=0, luma for k=1 and k=3, and Cr for k=2. Bytes 4g..4g+3 belong to pixels 2g and 2g+1.
- R2: With `in_order` = 1, byte position k mod 4 carries luma for k=0 and k=2, Cb for k=1 and Cr for k=3.
- R3: Only the first OUT_W pixels (2*OUT_W bytes) of each row produce output. The remaining bytes are consumed without producing any output, and the input has no ready signal.
- R4: Output luma row 2p equals input row 2p's luma, sample for sample.
- R5: Output luma row 2p+1 at column x equals clamp((−32·A + 160·B + 160·C − 32·D + 128) >>> 8, 0, 255). A, B, C and D are the luma of input rows 2(p−1), 2p, 2(p+1) and 2(p+2) at column x, and each row index is clamped to the range 0..ROWS−2 of even rows.
- R6: On each frame, chroma rows come only from even input rows, with values unchanged. Each chroma plane has OUT_W/2 samples per row and ROWS/2 rows. Odd input rows produce no chroma.
- R7: Each frame yields exactly ROWS luma rows of OUT_W samples in ascending row order. This includes the final rows, which are emitted after the frame's last input byte without further input.
- R8: On every port, the line-start marker is set on the first sample of each output row and the line-end marker on its last sample.
- R9: Plane tags are 0 on the luma port, 1 on the Cb port and 2 on the Cr port.
- R10: Emission of luma row pair p starts once even input row min(2p+4, ROWS−2) has delivered its last kept luma byte. The luma output is idle again before the next frame-start byte, provided the blanking between frames is at least 6·OUT_W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Packed input byte |
| in_sof | input | 1 | First byte of a frame |
| in_sol | input | 1 | First byte of a row |
| in_order | input | 1 | Byte order select: 0 chroma-first, 1 luma-first |
| y_valid | output | 1 | Luma sample strobe |
| y_data | output | 8 | Luma sample |
| y_sol | output | 1 | First luma sample of a row |
| y_eol | output | 1 | Last luma sample of a row |
| y_plane | output | 2 | Luma plane tag |
| cb_valid | output | 1 | Cb sample strobe |
| cb_data | output | 8 | Cb sample |
| cb_sol | output | 1 | First Cb sample of a row |
| cb_eol | output | 1 | Last Cb sample of a row |
| cb_plane | output | 2 | Cb plane tag |
| cr_valid | output | 1 | Cr sample strobe |
| cr_data | output | 8 | Cr sample |
| cr_sol | output | 1 | First Cr sample of a row |
| cr_eol | output | 1 | Last Cr sample of a row |
| cr_plane | output | 2 | Cr plane tag |

## Verification
The in-line assertions check several rules on every cycle:
- Cb and Cr never appear together.
- Cropped bytes and odd-row bytes never produce chroma.
- Every luma row has its markers at the first and last of exactly OUT_W samples.
- A luma pair is never triggered while the previous pair is still draining.
- A frame never starts while luma is still draining.

Sample values need the bench's scenarios. These cover the rebuilt odd rows, including both clamp limits and edge-row replication at the top and bottom, the two byte orders, the exact count of each plane per frame, and the absence of stray outputs under bursty input.

// File: rtl/uyvy420_pkg.sv
`timescale 1ns/1ps
package uyvy420_pkg;
   localparam int PIX_W = 8;

   typedef enum logic [1:0] {
      PLANE_Y  = 2'd0,
      PLANE_CB = 2'd1,
      PLANE_CR = 2'd2
   } plane_e;

   typedef enum logic [1:0] {
      LANE_Y,
      LANE_CB,
      LANE_CR
   } lane_e;

   // Byte lane of a position within a 4-byte pixel pair
   function automatic lane_e lane_of(input logic [1:0] pos, input logic luma_first);
      case ({luma_first, pos})
         3'b000:  return LANE_CB;
         3'b001:  return LANE_Y;
         3'b010:  return LANE_CR;
         3'b011:  return LANE_Y;
         3'b100:  return LANE_Y;
         3'b101:  return LANE_CB;
         3'b110:  return LANE_Y;
         default: return LANE_CR;
      endcase
   endfunction
endpackage

// File: rtl/uyvy420_lane_sort.sv
`timescale 1ns/1ps
module uyvy420_lane_sort
   import uyvy420_pkg::*;
#(
   parameter int IN_W  = 720,
   parameter int OUT_W = 704,
   parameter int ROWS  = 480
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic                      in_sof,
   input  logic                      in_sol,
   input  logic                      in_order,
   output logic                      y_we,
   output logic                      cb_we,
   output logic                      cr_we,
   output logic [$clog2(OUT_W)-1:0]  pix_col,
   output logic [$clog2(OUT_W)-1:0]  pair_col,
   output logic [$clog2(ROWS/2)-1:0] even_idx,
   output logic                      row_odd,
   output logic                      kept
);
   localparam int CW = $clog2(2*IN_W+1);
   localparam int RW = $clog2(ROWS);
   localparam int XW = $clog2(OUT_W);
   localparam int EW = $clog2(ROWS/2);

   logic [CW-1:0] col_q, cur_col;
   logic [RW-1:0] row_q, cur_row;
   lane_e         lane;

   always_comb begin
      cur_col = in_sol ? '0 : col_q;
      if (in_sof)      cur_row = '0;
      else if (in_sol) cur_row = row_q + RW'(1);
      else             cur_row = row_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (in_valid) begin
         col_q <= cur_col + CW'(1);
         row_q <= cur_row;
      end
   end

   assign lane     = lane_of(cur_col[1:0], in_order);
   assign kept     = cur_col < CW'(2*OUT_W);
   assign row_odd  = cur_row[0];
   assign pix_col  = XW'(cur_col >> 1);
   assign pair_col = XW'(cur_col >> 2);
   assign even_idx = EW'(cur_row >> 1);
   assign y_we     = in_valid && kept && !row_odd && (lane == LANE_Y);
   assign cb_we    = in_valid && kept && !row_odd && (lane == LANE_CB);
   assign cr_we    = in_valid && kept && !row_odd && (lane == LANE_CR);
endmodule

// File: rtl/uyvy420_chroma_lane.sv
`timescale 1ns/1ps
module uyvy420_chroma_lane
   import uyvy420_pkg::*;
#(
   parameter int OUT_W = 704
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(OUT_W)-1:0] col,
   input  logic [PIX_W-1:0]         din,
   output logic                     valid,
   output logic [PIX_W-1:0]         dout,
   output logic                     sol,
   output logic                     eol
);
   localparam int XW    = $clog2(OUT_W);
   localparam int C_MAX = OUT_W/2 - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
         sol   <= 1'b0;
         eol   <= 1'b0;
      end else begin
         valid <= we;
         if (we) begin
            dout <= din;
            sol  <= (col == '0);
            eol  <= (col == XW'(C_MAX));
         end
      end
   end
endmodule

// File: rtl/uyvy420_interp4.sv
`timescale 1ns/1ps
module uyvy420_interp4
   import uyvy420_pkg::*;
#(
   parameter int W_OUT = -32,
   parameter int W_IN  = 160,
   parameter int SHIFT = 8
) (
   input  logic [PIX_W-1:0] a,
   input  logic [PIX_W-1:0] b,
   input  logic [PIX_W-1:0] c,
   input  logic [PIX_W-1:0] d,
   output logic [PIX_W-1:0] y
);
   localparam int MAXV = (1 << PIX_W) - 1;

   if (2*W_OUT + 2*W_IN != (1 << SHIFT)) begin : g_bad_gain
      $error("interp4: taps must sum to unity gain");
   end

   int s;

   always_comb begin
      s = W_IN * (int'(b) + int'(c)) + W_OUT * (int'(a) + int'(d)) + (1 <<< (SHIFT-1));
      s = s >>> SHIFT;
      if (s < 0)         y = '0;
      else if (s > MAXV) y = '1;
      else               y = PIX_W'(s);
   end
endmodule

// File: rtl/uyvy420_luma_deint.sv
`timescale 1ns/1ps
module uyvy420_luma_deint
   import uyvy420_pkg::*;
#(
   parameter int OUT_W = 704,
   parameter int ROWS  = 480
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [$clog2(OUT_W)-1:0]  col,
   input  logic [$clog2(ROWS/2)-1:0] eidx,
   input  logic [PIX_W-1:0]          din,
   output logic                      y_valid,
   output logic [PIX_W-1:0]          y_data,
   output logic                      y_sol,
   output logic                      y_eol,
   output logic                      busy
);
   localparam int XW    = $clog2(OUT_W);
   localparam int EW    = $clog2(ROWS/2);
   localparam int N_EV  = ROWS/2;
   localparam int NBUF  = 4;
   localparam int LASTX = OUT_W - 1;

   logic [PIX_W-1:0] rd_all [NBUF];

   // one line store per even row in the filter window
   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      logic [PIX_W-1:0] mem [OUT_W];
      logic [PIX_W-1:0] rd;
      always_ff @(posedge clk) begin
         if (we && (eidx[1:0] == 2'(g))) mem[col] <= din;
         rd <= mem[x_q];
      end
      assign rd_all[g] = rd;
   end

   logic          act, half_q, trig;
   logic [XW-1:0] x_q;
   logic [EW-1:0] pair_q;
   logic [1:0]    pend_q;

   assign trig = we && (col == XW'(LASTX)) && (eidx >= EW'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0; half_q <= 1'b0; x_q <= '0; pair_q <= '0; pend_q <= '0;
      end else if (trig) begin
         act    <= 1'b1;
         half_q <= 1'b0;
         x_q    <= '0;
         pair_q <= eidx - EW'(2);
         pend_q <= (eidx == EW'(N_EV-1)) ? 2'd2 : 2'd0;
      end else if (act) begin
         if (x_q == XW'(LASTX)) begin
            x_q <= '0;
            if (!half_q) half_q <= 1'b1;
            else if (pend_q != 2'd0) begin
               half_q <= 1'b0;
               pair_q <= pair_q + EW'(1);
               pend_q <= pend_q - 2'd1;
            end else act <= 1'b0;
         end else x_q <= x_q + XW'(1);
      end
   end

   function automatic logic [1:0] slot(input int t);
      int u;
      u = (t < 0) ? 0 : ((t > N_EV-1) ? N_EV-1 : t);
      return u[1:0];
   endfunction

   logic [3:0][1:0] sel_c, sel1;
   logic            v1, half1, sol1, eol1;

   always_comb begin
      for (int k = 0; k < 4; k++) sel_c[k] = slot(int'(pair_q) + k - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; half1 <= 1'b0; sol1 <= 1'b0; eol1 <= 1'b0; sel1 <= '0;
      end else begin
         v1    <= act;
         half1 <= half_q;
         sol1  <= (x_q == '0);
         eol1  <= (x_q == XW'(LASTX));
         sel1  <= sel_c;
      end
   end

   logic [PIX_W-1:0] tap_a, tap_b, tap_c, tap_d, mid;
   assign tap_a = rd_all[sel1[0]];
   assign tap_b = rd_all[sel1[1]];
   assign tap_c = rd_all[sel1[2]];
   assign tap_d = rd_all[sel1[3]];

   uyvy420_interp4 u_interp (.a(tap_a), .b(tap_b), .c(tap_c), .d(tap_d), .y(mid));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_valid <= 1'b0; y_data <= '0; y_sol <= 1'b0; y_eol <= 1'b0;
      end else begin
         y_valid <= v1;
         if (v1) begin
            y_data <= half1 ? mid : tap_b;
            y_sol  <= sol1;
            y_eol  <= eol1;
         end
      end
   end

   assign busy = act || v1 || y_valid;

   // samples seen so far in the current output row
   logic [XW-1:0] ycnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ycnt <= '0;
      else if (y_valid) ycnt <= y_eol ? '0 : ycnt + XW'(1);
   end

   AST_Y_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid && y_eol |-> ycnt == XW'(LASTX)); // R7
   AST_Y_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid && y_sol |-> ycnt == '0); // R8
   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> !act); // R10
endmodule

// File: rtl/uyvy420_split.sv
`timescale 1ns/1ps
module uyvy420_split
   import uyvy420_pkg::*;
#(
   parameter int IN_W  = 720,
   parameter int OUT_W = 704,
   parameter int ROWS  = 480
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] in_data,
   input  logic             in_sof,
   input  logic             in_sol,
   input  logic             in_order,
   output logic             y_valid,
   output logic [PIX_W-1:0] y_data,
   output logic             y_sol,
   output logic             y_eol,
   output logic [1:0]       y_plane,
   output logic             cb_valid,
   output logic [PIX_W-1:0] cb_data,
   output logic             cb_sol,
   output logic             cb_eol,
   output logic [1:0]       cb_plane,
   output logic             cr_valid,
   output logic [PIX_W-1:0] cr_data,
   output logic             cr_sol,
   output logic             cr_eol,
   output logic [1:0]       cr_plane
);
   localparam int XW = $clog2(OUT_W);
   localparam int EW = $clog2(ROWS/2);

   if (OUT_W % 2 != 0 || OUT_W < 2 || OUT_W > IN_W) begin : g_bad_width
      $error("uyvy420_split: OUT_W must be even and within IN_W");
   end
   if (ROWS % 2 != 0 || ROWS < 6) begin : g_bad_rows
      $error("uyvy420_split: ROWS must be even and at least 6");
   end

   logic          y_we, cb_we, cr_we, row_odd, kept, busy;
   logic [XW-1:0] pix_col, pair_col;
   logic [EW-1:0] even_idx;

   uyvy420_lane_sort #(.IN_W(IN_W), .OUT_W(OUT_W), .ROWS(ROWS)) u_sort (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_sol(in_sol), .in_order(in_order), .y_we(y_we), .cb_we(cb_we),
      .cr_we(cr_we), .pix_col(pix_col), .pair_col(pair_col),
      .even_idx(even_idx), .row_odd(row_odd), .kept(kept));

   uyvy420_luma_deint #(.OUT_W(OUT_W), .ROWS(ROWS)) u_luma (
      .clk(clk), .rst_n(rst_n), .we(y_we), .col(pix_col), .eidx(even_idx),
      .din(in_data), .y_valid(y_valid), .y_data(y_data), .y_sol(y_sol),
      .y_eol(y_eol), .busy(busy));

   uyvy420_chroma_lane #(.OUT_W(OUT_W)) u_cb (
      .clk(clk), .rst_n(rst_n), .we(cb_we), .col(pair_col), .din(in_data),
      .valid(cb_valid), .dout(cb_data), .sol(cb_sol), .eol(cb_eol));

   uyvy420_chroma_lane #(.OUT_W(OUT_W)) u_cr (
      .clk(clk), .rst_n(rst_n), .we(cr_we), .col(pair_col), .din(in_data),
      .valid(cr_valid), .dout(cr_data), .sol(cr_sol), .eol(cr_eol));

   assign y_plane  = PLANE_Y;
   assign cb_plane = PLANE_CB;
   assign cr_plane = PLANE_CR;

   AST_CB_CR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cb_valid && cr_valid)); // R1
   AST_CROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !kept |=> !cb_valid && !cr_valid); // R3
   AST_ODD_ROW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && row_odd |=> !cb_valid && !cr_valid); // R6
   AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_sof |-> !busy); // R10
endmodule

// File: tb/tb_uyvy420_split.sv
`timescale 1ns/1ps
module tb_uyvy420_split;
   localparam int IN_W  = 12;
   localparam int OUT_W = 8;
   localparam int ROWS  = 8;
   localparam int NE    = ROWS/2;

   typedef struct {
      int v;
      bit s;
      bit e;
      int tag;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_order = 1'b0;
   logic [7:0] in_data = '0;
   logic y_valid, y_sol, y_eol, cb_valid, cb_sol, cb_eol, cr_valid, cr_sol, cr_eol;
   logic [7:0] y_data, cb_data, cr_data;
   logic [1:0] y_plane, cb_plane, cr_plane;

   uyvy420_split #(.IN_W(IN_W), .OUT_W(OUT_W), .ROWS(ROWS)) dut (.*);

   always #2.5 clk = ~clk;

   int tests = 0, fails = 0;
   int ycnt = 0, cbcnt = 0, crcnt = 0;
   exp_t yq[$], cbq[$], crq[$];
   int lum [ROWS][IN_W];
   int cbv [ROWS][IN_W/2];
   int crv [ROWS][IN_W/2];

   function automatic string tname(input int t);
      case (t)
         1: return "R1";  2: return "R2";  3: return "R3";
         4: return "R4";  5: return "R5";  6: return "R6";
         7: return "R7";  8: return "R8";  9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int cl(input int j);
      return (j < 0) ? 0 : ((j > NE-1) ? NE-1 : j);
   endfunction

   // expected planes from the requirements
   task automatic build_expect(input int ctag);
      for (int r = 0; r < ROWS; r++) begin
         for (int x = 0; x < OUT_W; x++) begin
            exp_t e;
            int p, s;
            p = r / 2;
            if (r % 2 == 0) begin
               e.v = lum[2*p][x]; e.tag = 4;                         // R4
            end else begin
               s = -32*lum[2*cl(p-1)][x] + 160*lum[2*p][x]
                   + 160*lum[2*cl(p+1)][x] - 32*lum[2*cl(p+2)][x] + 128; // R5
               s = s >>> 8;
               e.v = (s < 0) ? 0 : ((s > 255) ? 255 : s); e.tag = 5;
            end
            e.s = (x == 0); e.e = (x == OUT_W-1);
            yq.push_back(e);
         end
      end
      for (int r = 0; r < ROWS; r += 2) begin
         for (int g = 0; g < OUT_W/2; g++) begin
            exp_t e;
            e.s = (g == 0); e.e = (g == OUT_W/2-1); e.tag = ctag;
            e.v = cbv[r][g]; cbq.push_back(e);
            e.v = crv[r][g]; crq.push_back(e);
         end
      end
   endtask

   task automatic drive_byte(input logic [7:0] b, input bit sof, input bit sol, input bit gaps);
      if (gaps && $urandom_range(0, 2) == 0) begin
         @(posedge clk); #1; in_valid = 1'b0;
      end
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = b; in_sof = sof; in_sol = sol;
   endtask

   task automatic send_frame(input bit order, input bit gaps);
      ycnt = 0; cbcnt = 0; crcnt = 0;
      build_expect(order ? 2 : 1);
      in_order = order;
      for (int r = 0; r < ROWS; r++) begin
         for (int g = 0; g < IN_W/2; g++) begin
            logic [7:0] b [4];
            if (!order) begin           // R1 chroma-first
               b[0] = 8'(cbv[r][g]); b[1] = 8'(lum[r][2*g]);
               b[2] = 8'(crv[r][g]); b[3] = 8'(lum[r][2*g+1]);
            end else begin              // R2 luma-first
               b[0] = 8'(lum[r][2*g]); b[1] = 8'(cbv[r][g]);
               b[2] = 8'(lum[r][2*g+1]); b[3] = 8'(crv[r][g]);
            end
            for (int k = 0; k < 4; k++)
               drive_byte(b[k], (r == 0 && g == 0 && k == 0), (g == 0 && k == 0), gaps);
         end
         if (gaps) begin
            @(posedge clk); #1; in_valid = 1'b0;
         end
      end
      @(posedge clk); #1;
      in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
      repeat (100) @(posedge clk);
      #1;
      chk(yq.size() == 0, "R10", yq.size(), 0);
      chk(ycnt == OUT_W*ROWS, "R7", ycnt, OUT_W*ROWS);
      chk(cbcnt == OUT_W/2*NE, "R6", cbcnt, OUT_W/2*NE);
      chk(crcnt == OUT_W/2*NE, "R6", crcnt, OUT_W/2*NE);
   endtask

   task automatic fill_random();
      for (int r = 0; r < ROWS; r++) begin
         for (int x = 0; x < IN_W; x++) lum[r][x] = int'($urandom_range(0, 255));
         for (int g = 0; g < IN_W/2; g++) begin
            cbv[r][g] = int'($urandom_range(0, 255));
            crv[r][g] = int'($urandom_range(0, 255));
         end
      end
   endtask

   // compare every output sample against the model queues
   always @(negedge clk) begin
      if (rst_n) begin
         exp_t e;
         if (y_valid) begin
            ycnt++;
            chk(y_plane == 2'd0, "R9", int'(y_plane), 0);
            if (yq.size() == 0) chk(1'b0, "R3", int'(y_data), -1);
            else begin
               e = yq.pop_front();
               chk(int'(y_data) == e.v, tname(e.tag), int'(y_data), e.v);
               chk(y_sol == e.s && y_eol == e.e, "R8", int'({y_sol, y_eol}), int'({e.s, e.e}));
            end
         end
         if (cb_valid) begin
            cbcnt++;
            chk(cb_plane == 2'd1, "R9", int'(cb_plane), 1);
            if (cbq.size() == 0) chk(1'b0, "R3", int'(cb_data), -1);
            else begin
               e = cbq.pop_front();
               chk(int'(cb_data) == e.v, tname(e.tag), int'(cb_data), e.v);
               chk(cb_sol == e.s && cb_eol == e.e, "R8", int'({cb_sol, cb_eol}), int'({e.s, e.e}));
            end
         end
         if (cr_valid) begin
            crcnt++;
            chk(cr_plane == 2'd2, "R9", int'(cr_plane), 2);
            if (crq.size() == 0) chk(1'b0, "R3", int'(cr_data), -1);
            else begin
               e = crq.pop_front();
               chk(int'(cr_data) == e.v, tname(e.tag), int'(cr_data), e.v);
               chk(cr_sol == e.s && cr_eol == e.e, "R8", int'({cr_sol, cr_eol}), int'({e.s, e.e}));
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++; tests++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk(!y_valid && !cb_valid && !cr_valid, "R7", int'({y_valid, cb_valid, cr_valid}), 0);

      // frame 1: chroma-first order, random content, continuous input
      fill_random();
      send_frame(1'b0, 1'b0);

      // frame 2: luma-first order, patterns driving both clamp limits (R5)
      fill_random();
      for (int j = 0; j < NE; j++)
         for (int x = 0; x < IN_W; x++)
            lum[2*j][x] = ((x % 2 == 0) == (j == 1 || j == 2)) ? 255 : 0;
      send_frame(1'b1, 1'b0);

      // frame 3: chroma-first order with idle cycles in the input (R3 crop under gaps)
      fill_random();
      send_frame(1'b0, 1'b1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule